// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a configuration port that lets a host load and inspect a small bank of 16-bit control registers over three wires: an active-low select, a serial clock and a single data line that both sides share. Every frame opens with a direction flag, then a 7-bit register address, then a 16-bit data word. For a write, the host drives the whole frame. For a read, the host drives only the flag and the address. The block then takes over the data line and shifts the addressed register's contents back out.

The port runs directly on the serial clock and has no other clock. All frame state clears asynchronously while the select is high, so every frame starts from a known point. The register bank has its own asynchronous reset. The bank's contents are presented in parallel, so neighbouring logic can decode enable bits and multi-bit level fields from them. The shared data pin is split at the port list into an input, an output and an output enable, which the pad ring combines into the bidirectional pin.

Top module: `spi3w_regbank`

## Requirements
- R1: While rstN is low, every register reads as zero on regFlat and sdioOe is 0.
- R2: A write frame consists of select low, then 24 bits on sdioIn, each sampled on a rising sclk edge. The bits are a flag of 0, then address bits 6 down to 0, then data bits 15 down to 0. After the 24th rising edge, register n holds the data on regFlat[n*16 +: 16].
- R3: A read frame starts with a flag of 1 and an address. For it, sdioOut presents data bits 15 down to 0 of the addressed register. Bit 15 is launched on the falling edge that follows the 8th rising edge, and each later bit on the next falling edge, so the host samples each bit on the following rising edge.
- R4: sdioOe is 0 throughout a write frame and during the flag and address bits of a read frame. It is 1 from the falling edge after the last address bit of a read until select rises. It drops to 0 as soon as select goes high.
- R5: A write frame that is ended by select rising before its 24th rising edge leaves every register unchanged.
- R6: Addresses at or above NUM_REGS have no register. A read of one returns all zeros, and a write to one changes no register.
- R7: A frame that follows an aborted frame is decoded from its own first bit, whatever the aborted frame left behind.
- R8: Rising sclk edges beyond the 24th within one frame have no effect. A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low frame select |
| rstN | input | 1 | Active-low asynchronous reset of the register bank |
| sdioIn | input | 1 | Data line as seen at the pad input |
| sdioOut | output | 1 | Data driven toward the pad during reads |
| sdioOe | output | 1 | Pad driver enable for sdioOut |
| regFlat | output | NUM_REGS*DATA_W | All register contents; register n occupies bits [n*DATA_W +: DATA_W] |

## Verification
The bench builds the block with NUM_REGS set to 6 rather than the default 8. This leaves address 6 and everything above it unmapped, so reads and writes to missing registers can be tested right next to the last real register. With a bank this small, the bench can compare every register after each frame and observe that aborted and out-of-range writes have no effect. The 7-bit address and 16-bit word keep their default widths, so frame length and turnaround position match the normal use.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  // Per-edge strobes from the frame sequencer to the datapath.
  typedef struct packed {
    logic shiftAddr;   // address bit arriving on this rising edge
    logic loadRead;    // last address bit of a read: fetch the word
    logic shiftData;   // data-phase bit on this rising edge
    logic commitWrite; // final data bit of a write: store the word
    logic driveEn;     // read data phase: pad driver may turn on
  } seqStrobes_t;

endpackage

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic        sclk,
  input  logic        csN,
  input  logic        sdioIn,
  output logic        rwFlag,
  output seqStrobes_t strobes
);

  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(ADDR_W + DATA_W);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] bitCnt;

  // Count rising edges in the frame, saturating after the last bit.
  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      bitCnt <= '0;
      rwFlag <= 1'b0;
    end else begin
      if (bitCnt != FULL_CNT) bitCnt <= bitCnt + 1'b1;
      if (bitCnt == '0) rwFlag <= sdioIn;
    end
  end

  always_comb begin
    strobes.shiftAddr   = (bitCnt != '0) && (bitCnt <= LAST_ADDR);
    strobes.loadRead    = (bitCnt == LAST_ADDR) && rwFlag;
    strobes.shiftData   = (bitCnt > LAST_ADDR) && (bitCnt <= LAST_DATA);
    strobes.commitWrite = (bitCnt == LAST_DATA) && !rwFlag;
    strobes.driveEn     = (bitCnt > LAST_ADDR) && rwFlag;
  end

  // R4: the direction flag holds once captured, unless the frame restarted
  assert_rw_hold_R4: assert property (@(posedge sclk) disable iff (csN)
    (bitCnt != '0) |=> ((bitCnt == '0) || $stable(rwFlag)));

  // R8: no second commit within one frame
  assert_single_commit_R8: assert property (@(posedge sclk) disable iff (csN)
    strobes.commitWrite |=> !strobes.commitWrite);

endmodule

// File: rtl/spi3w_datapath.sv
module spi3w_datapath
  import spi3w_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8
) (
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       rstN,
  input  logic                       sdioIn,
  input  seqStrobes_t                strobes,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);

  logic [ADDR_W-1:0] addrShift;
  logic [DATA_W-1:0] dataShift;
  logic [DATA_W-1:0] readShift;
  logic [DATA_W-1:0] readWord;
  logic [ADDR_W-1:0] readAddr;
  logic [DATA_W-1:0] commitWord;
  logic [DATA_W-1:0] bank [NUM_REGS];

  // The final incoming bit joins the shifted value on the same edge.
  assign readAddr   = {addrShift[ADDR_W-2:0], sdioIn};
  assign commitWord = {dataShift[DATA_W-2:0], sdioIn};

  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      addrShift <= '0;
      dataShift <= '0;
    end else begin
      if (strobes.shiftAddr) addrShift <= readAddr;
      if (strobes.shiftData) dataShift <= commitWord;
    end
  end

  // Register bank with one decoder per entry.
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(k);
    always_ff @(posedge sclk or negedge rstN) begin
      if (!rstN) bank[k] <= '0;
      else if (strobes.commitWrite && (addrShift == MY_ADDR)) bank[k] <= commitWord;
    end
    assign regFlat[k*DATA_W +: DATA_W] = bank[k];
  end

  // Read selection: unmapped addresses fall through to zero.
  always_comb begin
    readWord = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (readAddr == ADDR_W'(k)) readWord = bank[k];
    end
  end

  always_ff @(posedge sclk or posedge csN) begin
    if (csN) readShift <= '0;
    else if (strobes.loadRead) readShift <= readWord;
    else if (strobes.shiftData) readShift <= {readShift[DATA_W-2:0], 1'b0};
  end

  // Launch on the falling edge; the driver stays on until select rises.
  always_ff @(negedge sclk or posedge csN) begin
    if (csN) begin
      sdioOe  <= 1'b0;
      sdioOut <= 1'b0;
    end else begin
      sdioOe  <= sdioOe | strobes.driveEn;
      sdioOut <= readShift[DATA_W-1];
    end
  end

  // R5: the bank only moves on a full-frame commit
  assert_bank_hold_R5: assert property (@(posedge sclk) disable iff (!rstN)
    !strobes.commitWrite |=> $stable(regFlat));

  // R6: a commit to a missing address changes nothing
  assert_unmapped_write_R6: assert property (@(posedge sclk) disable iff (!rstN)
    (strobes.commitWrite && (32'(addrShift) >= NUM_REGS)) |=> $stable(regFlat));

  // R6: a read of a missing address fetches zero
  assert_unmapped_read_R6: assert property (@(posedge sclk) disable iff (csN)
    (strobes.loadRead && (32'(readAddr) >= NUM_REGS)) |=> (readShift == '0));

endmodule

// File: rtl/spi3w_regbank.sv
module spi3w_regbank
  import spi3w_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8
) (
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       rstN,
  input  logic                       sdioIn,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);

  seqStrobes_t strobes;
  logic        rwFlag;

  spi3w_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .sclk    (sclk),
    .csN     (csN),
    .sdioIn  (sdioIn),
    .rwFlag  (rwFlag),
    .strobes (strobes)
  );

  spi3w_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .sclk    (sclk),
    .csN     (csN),
    .rstN    (rstN),
    .sdioIn  (sdioIn),
    .strobes (strobes),
    .sdioOut (sdioOut),
    .sdioOe  (sdioOe),
    .regFlat (regFlat)
  );

  // R4: never drive the pin during a write frame
  assert_no_drive_write_R4: assert property (@(negedge sclk) disable iff (csN)
    !rwFlag |-> !sdioOe);

  // R4: the pin is released while select is high
  assert_release_idle_R4: assert property (@(posedge sclk) disable iff (!rstN)
    csN |-> !sdioOe);

endmodule

// File: tb/sim_spi3w_regbank.sv
module sim_spi3w_regbank;

  localparam int CLK_PERIOD = 20;
  localparam int NREG = 6;
  localparam int AW   = 7;
  localparam int DW   = 16;

  logic sclk = 1'b0, csN = 1'b1, rstN = 1'b0, sdioIn = 1'b0;
  logic sdioOut, sdioOe;
  logic [NREG*DW-1:0] regFlat;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [NREG];
  logic [DW-1:0] expQ [$];
  string tagQ [$];
  logic [DW-1:0] monWord;
  int monCnt = 0;

  spi3w_regbank #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NREG)) u0 (
    .sclk(sclk), .csN(csN), .rstN(rstN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .regFlat(regFlat)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NREG*DW-1:0] act, input logic [NREG*DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NREG*DW-1:0] modelFlat();
    logic [NREG*DW-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*DW +: DW] = model[k];
    return f;
  endfunction

  task automatic checkRegs(input string req);
    check(regFlat === modelFlat(), req, "register bank", regFlat, modelFlat());
  endtask

  // Driver: one frame of nBits rising edges; reads push expected words.
  task automatic frame(input bit rd, input logic [AW-1:0] addr, input logic [DW-1:0] data,
                       input int nBits, input string req);
    logic [AW+DW:0] bits;
    int oeBad;
    bits  = {rd, addr, data};
    oeBad = 0;
    if (rd && nBits >= AW + DW + 1) begin
      expQ.push_back((32'(addr) < NREG) ? model[addr] : '0);
      tagQ.push_back(req);
    end
    csN = 1'b0;
    #(CLK_PERIOD);
    for (int i = 0; i < nBits; i++) begin
      sdioIn = (i <= AW + DW) ? bits[AW+DW-i] : 1'b0;
      #(CLK_PERIOD/4);
      if (sdioOe !== (rd && i > AW)) oeBad++;
      #(CLK_PERIOD/4);
      sclk = 1'b1;
      #(CLK_PERIOD/2);
      sclk = 1'b0;
    end
    #(CLK_PERIOD/2);
    check(oeBad == 0, "R4", "driver enable per bit", oeBad, 0);
    csN = 1'b1;
    #(CLK_PERIOD/4);
    check(sdioOe === 1'b0, "R4", "release after select", sdioOe, 0);
    #(CLK_PERIOD);
    if (!rd && nBits >= AW + DW + 1 && 32'(addr) < NREG) model[addr] = data;
  endtask

  // Monitor: collects driven bits and compares against the queue.
  always @(posedge sclk) begin
    if (!csN && sdioOe) begin
      monWord = {monWord[DW-2:0], sdioOut};
      monCnt++;
      if (monCnt == DW) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected read word", monWord, 0);
        end else begin
          logic [DW-1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(monWord === e, t, "read word", monWord, e);
        end
      end
    end
  end

  always @(posedge csN) monCnt = 0;

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = '0;
    #(3*CLK_PERIOD);
    check(regFlat === '0, "R1", "bank in reset", regFlat, '0);
    check(sdioOe === 1'b0, "R1", "driver in reset", sdioOe, 0);
    rstN = 1'b1;
    #(CLK_PERIOD);

    // R2 single write, R8 others untouched
    frame(1'b0, 7'd2, 16'hA5C3, 24, "R2");
    checkRegs("R2");
    checkRegs("R8");

    // R2 fill every register, R3 read each back
    for (int k = 0; k < NREG; k++) frame(1'b0, AW'(k), 16'h1111 * (k + 1) ^ 16'h8001, 24, "R2");
    checkRegs("R2");
    for (int k = 0; k < NREG; k++) frame(1'b1, AW'(k), '0, 24, "R3");

    // R3 edge patterns
    frame(1'b0, 7'd0, 16'hFFFF, 24, "R2");
    frame(1'b0, 7'd5, 16'h8000, 24, "R2");
    frame(1'b0, 7'd4, 16'h0001, 24, "R2");
    frame(1'b1, 7'd0, '0, 24, "R3");
    frame(1'b1, 7'd5, '0, 24, "R3");
    frame(1'b1, 7'd4, '0, 24, "R3");

    // R5 aborted writes
    frame(1'b0, 7'd1, 16'h0F0F, 23, "R5");
    checkRegs("R5");
    frame(1'b0, 7'd3, 16'hDEAD, 5, "R5");
    checkRegs("R5");

    // R6 unmapped write and read
    frame(1'b0, 7'd100, 16'hBEEF, 24, "R6");
    checkRegs("R6");
    frame(1'b0, 7'd6, 16'h1234, 24, "R6");
    checkRegs("R6");
    frame(1'b1, 7'd100, '0, 24, "R6");
    frame(1'b1, 7'd6, '0, 24, "R6");
    frame(1'b1, 7'd127, '0, 24, "R6");

    // R8 extra clocks after a full write, then after a full read
    frame(1'b0, 7'd3, 16'h5A5A, 28, "R8");
    checkRegs("R8");
    frame(1'b1, 7'd3, '0, 27, "R8");

    // R7 aborted read, then clean write and read
    frame(1'b1, 7'd2, '0, 12, "R7");
    frame(1'b0, 7'd2, 16'hC0DE, 24, "R7");
    checkRegs("R7");
    frame(1'b1, 7'd2, '0, 24, "R7");

    check(expQ.size() == 0, "R3", "pending read words", expQ.size(), 0);
    finishRun();
  end

endmodule